// File: doc/BRIEF.md
# Link Bandwidth Change Notifier

This block sits on the register side of a serial link port. It records that the link changed its bandwidth and raises an interrupt request when that happens. The link state machine reports each completed speed change with a one-cycle pulse and a tag. The tag marks the change as either autonomous, meaning the hardware started it on its own (for example to save power), or management-initiated, meaning software retraining or a link reliability problem caused it.

Software reaches the block through a simple register port with byte-addressed offsets and a write strobe. Through it, software can:
- turn the notification capability on or off;
- enable an interrupt for each kind of change;
- forbid hardware-autonomous speed changes;
- program a target link speed;
- request a retrain;
- read and clear the two sticky status bits.

The interrupt output is a level. It stays high while an enabled status bit is set.

Top module: `link_bw_notify`

## Requirements
- R1: After reset, the registers hold these values: capability bit (offset 0x0 bit 0) = 1, all control bits = 0, target speed = 4, both status bits = 0. In this state `irq` = 0, `allow_auto` = 1 and `retrain_pulse` = 0.
- R2: When `chg_pulse` is high and the capability bit is 1, a status bit sets at the next clock edge. The status register is at offset 0xC. `chg_auto` = 0 sets the management bit (bit 0) and `chg_auto` = 1 sets the autonomous bit (bit 1).
- R3: `irq` is high exactly when the management status and its enable (control offset 0x4 bit 0) are both 1, or when the autonomous status and its enable (bit 1) are both 1.
- R4: While the autonomous-disable bit (offset 0x4 bit 3) is 1, `allow_auto` is 0. Otherwise `allow_auto` is 1.
- R5: A write with data bit 2 set at offset 0x4 gives `retrain_pulse` = 1 for exactly the next cycle, but only when `port_dsp` = 1 during the write. When `port_dsp` = 0, the write is ignored and no pulse follows.
- R6: The retrain bit reads back as 1 only during the cycle of its pulse. After that it reads 0 again without any further write.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. When a clear and a set of the same bit fall in the same cycle, the bit ends up set.
- R8: The target speed field is offset 0x8 bits [3:0]. Writes of values 1 to 4 update it and appear on `target_speed`. Writes of any other value leave it unchanged.
- R9: While the capability bit is 0, `chg_pulse` leaves both status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| chg_pulse | input | 1 | One-cycle report of a completed speed change |
| chg_auto | input | 1 | Tag for `chg_pulse`: 1 = autonomous, 0 = management |
| port_dsp | input | 1 | 1 when the port faces downstream |
| irq | output | 1 | Level interrupt request |
| allow_auto | output | 1 | Permission for hardware-autonomous speed changes |
| retrain_pulse | output | 1 | One-cycle retrain request |
| target_speed | output | 4 | Programmed target speed, encoded 1 to 4 |

## Verification
The assertions assume that `chg_pulse` carries a valid `chg_auto` tag whenever it is high. They also assume that the register port's inputs are stable around each clock edge. The one on rising interrupts further assumes that only a change report or a register write can make `irq` rise.

The stimulus keeps to these assumptions:
- It drives every input on the falling edge.
- It presents at most one write per cycle.
- It draws `chg_auto` together with `chg_pulse`.

A directed phase covers the same-cycle clear-and-set case and retrain writes from both port orientations. A random phase then mixes writes to all four offsets, change pulses and port orientation.

// File: rtl/link_bw_notify.sv
module link_bw_notify #(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter logic [3:0] TGT_RESET = 4'd4,
  parameter logic [3:0] TGT_MAX = 4'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          chg_pulse,
  input  logic          chg_auto,
  input  logic          port_dsp,
  output logic          irq,
  output logic          allow_auto,
  output logic          retrain_pulse,
  output logic [3:0]    target_speed
);
  localparam logic [AW-1:0] OFS_CAP  = AW'(4'h0);
  localparam logic [AW-1:0] OFS_CTRL = AW'(4'h4);
  localparam logic [AW-1:0] OFS_TGT  = AW'(4'h8);
  localparam logic [AW-1:0] OFS_STS  = AW'(4'hC);

  logic       cap_q;
  logic       mgmt_ie_q, auto_ie_q, auto_dis_q, retrain_q;
  logic [3:0] tgt_q;
  logic       mgmt_sts_q, auto_sts_q;

  wire wr_cap  = reg_wr && reg_addr == OFS_CAP;
  wire wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
  wire wr_tgt  = reg_wr && reg_addr == OFS_TGT;
  wire wr_sts  = reg_wr && reg_addr == OFS_STS;

  wire       tgt_ok    = reg_wdata[3:0] != 4'd0 && reg_wdata[3:0] <= TGT_MAX;
  wire       set_mgmt  = cap_q && chg_pulse && !chg_auto;
  wire       set_auto  = cap_q && chg_pulse && chg_auto;
  wire       clr_mgmt  = wr_sts && reg_wdata[0];
  wire       clr_auto  = wr_sts && reg_wdata[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q      <= 1'b1;
      mgmt_ie_q  <= 1'b0;
      auto_ie_q  <= 1'b0;
      auto_dis_q <= 1'b0;
      retrain_q  <= 1'b0;
      tgt_q      <= TGT_RESET;
      mgmt_sts_q <= 1'b0;
      auto_sts_q <= 1'b0;
    end else begin
      if (wr_cap) cap_q <= reg_wdata[0];
      if (wr_ctrl) begin
        mgmt_ie_q  <= reg_wdata[0];
        auto_ie_q  <= reg_wdata[1];
        auto_dis_q <= reg_wdata[3];
      end
      retrain_q <= wr_ctrl && reg_wdata[2] && port_dsp;
      if (wr_tgt && tgt_ok) tgt_q <= reg_wdata[3:0];
      mgmt_sts_q <= set_mgmt || (mgmt_sts_q && !clr_mgmt);
      auto_sts_q <= set_auto || (auto_sts_q && !clr_auto);
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CAP:  reg_rdata[0]   = cap_q;
      OFS_CTRL: reg_rdata[3:0] = {auto_dis_q, retrain_q, auto_ie_q, mgmt_ie_q};
      OFS_TGT:  reg_rdata[3:0] = tgt_q;
      OFS_STS:  reg_rdata[1:0] = {auto_sts_q, mgmt_sts_q};
      default:  reg_rdata      = '0;
    endcase
  end

  assign irq           = (mgmt_sts_q && mgmt_ie_q) || (auto_sts_q && auto_ie_q);
  assign allow_auto    = !auto_dis_q;
  assign retrain_pulse = retrain_q;
  assign target_speed  = tgt_q;
endmodule

// File: rtl/link_bw_notify_chk.sv
module link_bw_notify_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] reg_addr,
  input logic       reg_wr,
  input logic [31:0] reg_wdata,
  input logic       chg_pulse,
  input logic       chg_auto,
  input logic       port_dsp,
  input logic       irq,
  input logic       allow_auto,
  input logic       retrain_pulse,
  input logic [3:0] target_speed,
  input logic       cap_q,
  input logic       mgmt_sts_q,
  input logic       auto_sts_q
);
  AST_NO_CAP_NO_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_q && !mgmt_sts_q && !auto_sts_q) |=> (!mgmt_sts_q && !auto_sts_q)); // R9
  AST_MGMT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q && chg_pulse && !chg_auto) |=> mgmt_sts_q); // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(chg_pulse) || $past(reg_wr))); // R3
  AST_AUTO_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h4 && reg_wdata[3]) |=> !allow_auto); // R4
  AST_RETRAIN_DSP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h4 && reg_wdata[2] && !port_dsp) |=> !retrain_pulse); // R5
  AST_RETRAIN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_pulse && !(reg_wr && reg_addr == 4'h4 && reg_wdata[2])) |=> !retrain_pulse); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'hC && reg_wdata[1] && cap_q && chg_pulse && chg_auto) |=> auto_sts_q); // R7
  AST_TGT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (target_speed >= 4'd1 && target_speed <= 4'd4)); // R8
endmodule

bind link_bw_notify link_bw_notify_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .chg_pulse(chg_pulse), .chg_auto(chg_auto), .port_dsp(port_dsp), .irq(irq),
  .allow_auto(allow_auto), .retrain_pulse(retrain_pulse), .target_speed(target_speed),
  .cap_q(cap_q), .mgmt_sts_q(mgmt_sts_q), .auto_sts_q(auto_sts_q)
);

// File: tb/link_bw_notify_tb_top.sv
module link_bw_notify_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic chg_pulse = 1'b0, chg_auto = 1'b0, port_dsp = 1'b1;
  logic irq, allow_auto, retrain_pulse;
  logic [3:0] target_speed;

  int vectors = 0, fails = 0;
  int m_cap, m_mie, m_aie, m_dis, m_rt, m_tgt, m_ms, m_as;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  link_bw_notify dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_cap;
      4: return m_dis * 8 + m_rt * 4 + m_aie * 2 + m_mie;
      8: return m_tgt;
      12: return m_as * 2 + m_ms;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cap = 1; m_mie = 0; m_aie = 0; m_dis = 0; m_rt = 0; m_tgt = 4; m_ms = 0; m_as = 0;
    end else begin
      int ns_m, ns_a;
      ns_m = m_ms; ns_a = m_as;
      if (reg_wr && reg_addr == 12) begin
        if (reg_wdata[0]) ns_m = 0;
        if (reg_wdata[1]) ns_a = 0;
      end
      if (chg_pulse && m_cap == 1) begin
        if (chg_auto) ns_a = 1; else ns_m = 1;
      end
      m_rt = (reg_wr && reg_addr == 4 && reg_wdata[2] && port_dsp) ? 1 : 0;
      if (reg_wr && reg_addr == 0) m_cap = reg_wdata[0];
      if (reg_wr && reg_addr == 4) begin
        m_mie = reg_wdata[0]; m_aie = reg_wdata[1]; m_dis = reg_wdata[3];
      end
      if (reg_wr && reg_addr == 8 && int'(reg_wdata[3:0]) >= 1 && int'(reg_wdata[3:0]) <= 4)
        m_tgt = reg_wdata[3:0];
      m_ms = ns_m; m_as = ns_a;
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("R2 R7 R9 R8 R6 readback", int'(reg_rdata), exp_rd(int'(reg_addr)));
      chk("R3 irq", int'(irq), ((m_ms && m_mie) || (m_as && m_aie)) ? 1 : 0);
      chk("R4 allow_auto", int'(allow_auto), m_dis ? 0 : 1);
      chk("R5 retrain_pulse", int'(retrain_pulse), m_rt);
      chk("R8 target_speed", int'(target_speed), m_tgt);
    end
  end

  task automatic cyc(input bit w, input int a, input int d, input bit p, input bit au);
    @(negedge clk);
    reg_wr = w; reg_addr = 4'(a); reg_wdata = 32'(d); chg_pulse = p; chg_auto = au;
  endtask

  task automatic idle(input int a);
    cyc(0, a, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_P/4);
    chk("R1 irq", int'(irq), 0);
    chk("R1 allow_auto", int'(allow_auto), 1);
    chk("R1 target", int'(target_speed), 4);
    idle(12);
    cyc(0, 12, 0, 1, 0);          // R2 mgmt event
    idle(12);
    cyc(0, 12, 0, 1, 1);          // R2 autonomous event
    idle(12);
    cyc(1, 4, 3, 0, 0);           // R3 enables
    idle(12);
    cyc(1, 12, 1, 0, 0);          // R7 clear mgmt only
    idle(12);
    cyc(1, 12, 2, 1, 1);          // R7 clear and set same cycle
    idle(12);
    cyc(1, 12, 3, 0, 0);
    idle(4);
    cyc(1, 4, 8, 0, 0);           // R4 disable autonomous
    idle(4);
    port_dsp = 1'b1;
    cyc(1, 4, 4, 0, 0);           // R5 R6 retrain, downstream
    idle(4); idle(4);
    port_dsp = 1'b0;
    cyc(1, 4, 4, 0, 0);           // R5 ignored upstream
    idle(4); idle(4);
    cyc(1, 8, 2, 0, 0); idle(8);  // R8 legal
    cyc(1, 8, 7, 0, 0); idle(8);  // R8 illegal
    cyc(1, 8, 0, 0, 0); idle(8);
    cyc(1, 0, 0, 0, 0); idle(12); // R9 capability off
    cyc(0, 12, 0, 1, 0); idle(12);
    cyc(0, 12, 0, 1, 1); idle(12);
    cyc(1, 0, 1, 0, 0); idle(12);
    for (int i = 0; i < 3000; i++) begin
      port_dsp = 1'($urandom);
      cyc(1'($urandom_range(0, 2) == 0), int'($urandom_range(0, 3)) * 4,
          int'($urandom_range(0, 15)), 1'($urandom_range(0, 3) == 0), 1'($urandom));
    end
    idle(0); idle(0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    done = 1;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule